// File: doc/BRIEF.md
# SPI clock and chip-select timing generator

This block produces the serial clock and the four chip-select lines of a serial flash controller, timed in cycles of a reference clock. A sequencer elsewhere asks for a transfer of a given number of serial clock cycles. The block then runs the sequence. It asserts chip select and waits a programmable setup time. It toggles the serial clock at the programmed rate and marks each edge with a sample strobe or a shift strobe. After the last edge it waits a programmable hold time, releases chip select and keeps it released for a programmable minimum time. If the next transfer targets a different device, a further programmable delay is inserted before chip select goes low again.

All timing and mode fields are captured into a shadow copy only while the enable input is low. A transfer freezes its own working copy of that shadow when it is accepted. Configuration edits made while enabled, or made while a transfer runs, therefore never disturb the waveform in progress. The chip-select field is put on the pins unchanged. It can hold a one-hot active-low pattern, or a device index when decoder mode feeds an external decoder. The idle flag tells software when every delay has expired.

Top module: `spi_tgen`

## Requirements
- R1: The serial clock period is 2×(div+1) reference clocks. Every edge follows the previous edge by exactly div+1 clocks, and a transfer of N cycles makes exactly 2N edges.
- R2: The serial clock rests at the CPOL level whenever chip select is released. It also rests there before the first edge and after the last edge of a transfer.
- R3: Each serial clock edge comes with a one-cycle strobe in the same cycle, and no strobe appears at any other time. A leading edge (away from the CPOL level) gives a sample strobe when CPHA=0 and a shift strobe when CPHA=1. A trailing edge gives the other strobe. Each transfer of N cycles gives N of each.
- R4: While a transfer holds the bus, cs_n shows the captured 4-bit select field unchanged: 1110, 1101, 1011 or 0111 for one-hot devices 0–3, or the device index in decoder mode. While released, cs_n is 1111, so the index 15 selects nothing.
- R5: The first serial clock edge comes setup+1 reference clocks after chip select is asserted.
- R6: Chip select is released hold + 2×(div+1) + 3 reference clocks after the last serial clock edge.
- R7: After release, idle returns gap + 2×(div+1) clocks later. A request held waiting is accepted in the first idle cycle, so the released time between back-to-back transfers is gap + 2×(div+1) + 1 clocks.
- R8: If the device key {decoder-mode bit, select field} differs from that of the previous accepted transfer and the switch delay is non-zero, chip select asserts that many clocks after acceptance. Otherwise it asserts in the cycle after acceptance. The first transfer after reset never waits.
- R9: busy is high from the cycle after acceptance until chip select is released, and cs_n is 1111 whenever busy is low. idle is high only when no transfer or delay is pending, so both flags are low during the release time.
- R10: Configuration inputs are captured only while enable is low. Edits made while enable is high, or made during a transfer, do not alter the current transfer or the resting clock level.
- R11: A request is accepted only when idle and enable are high and the length is non-zero. Otherwise it is ignored: idle stays high and cs_n stays 1111.
- R12: After reset sclk is 0, cs_n is 1111, idle is 1, and busy and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Low: capture configuration; high: accept transfers |
| cpol | input | 1 | Serial clock resting level |
| cpha | input | 1 | Sampling edge select (0 leading, 1 trailing) |
| baud_div | input | 4 | Clock divisor, period 2×(div+1) |
| cs_sel | input | 4 | Select field, one-hot active low or device index |
| cs_decode | input | 1 | Decoder mode flag (part of the device key) |
| dly_setup | input | 8 | Select-to-first-edge delay |
| dly_hold | input | 8 | Last-edge-to-release delay (hardware adds one period + 3) |
| dly_switch | input | 8 | Extra release time when the device changes |
| dly_gap | input | 8 | Minimum release time (hardware adds one period + 1) |
| xfer_req | input | 1 | Transfer request |
| xfer_len | input | 8 | Serial clock cycles in the transfer |
| sclk | output | 1 | Serial clock |
| cs_n | output | 4 | Chip-select lines |
| sample_stb | output | 1 | Data sample strobe |
| shift_stb | output | 1 | Data shift strobe |
| busy | output | 1 | Transfer holds the bus |
| idle | output | 1 | No transfer and all delays expired |

## Verification
The closest coincidence is a request that is already pending when the release delay expires. The one idle cycle and the acceptance then fall together, and the next transfer starts with no margin. The bench holds xfer_req high across a whole transfer and its release time. It then measures the released interval between the two chip-select assertions and requires exactly gap + 2×(div+1) + 1 clocks, with no cycle lost or gained. A second overlap is a configuration edit that lands in the middle of a transfer. Enable is dropped and the divisor and hold fields change while the clock is running, and the bench judges the whole waveform against the values captured at acceptance.

// File: rtl/spi_tgen_pkg.sv
package spi_tgen_pkg;

    localparam int DIV_W = 4;
    localparam int DLY_W = 8;
    localparam int CS_W  = 4;
    // Longest state: an 8-bit delay plus two half periods plus three.
    localparam int TMR_W = ((DLY_W > DIV_W + 1) ? DLY_W : DIV_W + 1) + 2;
    localparam int KEY_W = CS_W + 1;

    typedef logic [TMR_W-1:0] tmr_t;

    typedef struct packed {
        logic             cpol;
        logic             cpha;
        logic [DIV_W-1:0] div;
        logic [CS_W-1:0]  cs_sel;
        logic             cs_dec;
        logic [DLY_W-1:0] d_setup;
        logic [DLY_W-1:0] d_hold;
        logic [DLY_W-1:0] d_switch;
        logic [DLY_W-1:0] d_gap;
    } tgen_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SWITCH,
        ST_SETUP,
        ST_RUN,
        ST_HOLD,
        ST_GAP
    } tgen_state_t;

    // Reference clocks per serial clock half period.
    function automatic tmr_t half_len(input logic [DIV_W-1:0] d);
        return tmr_t'(d) + tmr_t'(1);
    endfunction

    // Hold after last edge: programmed + one serial period + 3.
    function automatic tmr_t hold_len(input tgen_cfg_t c);
        return tmr_t'(c.d_hold) + (half_len(c.div) << 1) + tmr_t'(3);
    endfunction

    // Release time before idle: programmed + one serial period
    // (the idle cycle itself supplies the extra reference clock).
    function automatic tmr_t gap_len(input tgen_cfg_t c);
        return tmr_t'(c.d_gap) + (half_len(c.div) << 1);
    endfunction

    function automatic logic [KEY_W-1:0] dev_key(input tgen_cfg_t c);
        return {c.cs_dec, c.cs_sel};
    endfunction

endpackage

// File: rtl/spi_tgen_cfg.sv
module spi_tgen_cfg
    import spi_tgen_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      enable,
    input  logic      accept,
    input  logic      at_idle,
    input  tgen_cfg_t cfg_in,
    output tgen_cfg_t eff
);

    tgen_cfg_t shadow_q;
    tgen_cfg_t work_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            work_q   <= '0;
        end else begin
            if (!enable) begin
                shadow_q <= cfg_in;
            end
            if (accept) begin
                work_q <= shadow_q;
            end
        end
    end

    // In idle the sequencer sees the live shadow (resting level, accept
    // decision); afterwards it sees the copy frozen for the transfer.
    always_comb begin
        eff = at_idle ? shadow_q : work_q;
    end

endmodule

// File: rtl/spi_tgen_seq.sv
module spi_tgen_seq
    import spi_tgen_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             xfer_req,
    input  logic [LEN_W-1:0] xfer_len,
    input  tgen_cfg_t        eff,
    output logic             accept,
    output tgen_state_t      state,
    output logic             sclk,
    output logic             sample_stb,
    output logic             shift_stb
);

    localparam int EDGE_W = LEN_W + 1;
    localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(1);

    tgen_state_t        state_q;
    tmr_t               cnt_q;
    logic [EDGE_W-1:0]  edges_q;
    logic               sclk_q;
    logic               samp_q;
    logic               shft_q;
    logic               have_last_q;
    logic [KEY_W-1:0]   last_key_q;

    logic toggle;
    logic leading;
    logic switch_needed;
    logic cnt_done;

    always_comb begin
        cnt_done      = (cnt_q == '0);
        accept        = (state_q == ST_IDLE) && enable && xfer_req
                        && (xfer_len != '0);
        switch_needed = have_last_q && (dev_key(eff) != last_key_q)
                        && (eff.d_switch != '0);
        toggle        = cnt_done && ((state_q == ST_SETUP) || (state_q == ST_RUN));
        leading       = (sclk_q == eff.cpol);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            cnt_q       <= '0;
            edges_q     <= '0;
            sclk_q      <= 1'b0;
            samp_q      <= 1'b0;
            shft_q      <= 1'b0;
            have_last_q <= 1'b0;
            last_key_q  <= '0;
        end else begin
            samp_q <= toggle & (leading ^ eff.cpha);
            shft_q <= toggle & ~(leading ^ eff.cpha);
            if (toggle) begin
                sclk_q <= ~sclk_q;
            end
            unique case (state_q)
                ST_IDLE: begin
                    sclk_q <= eff.cpol;
                    if (accept) begin
                        have_last_q <= 1'b1;
                        last_key_q  <= dev_key(eff);
                        edges_q     <= {xfer_len, 1'b0};
                        if (switch_needed) begin
                            state_q <= ST_SWITCH;
                            cnt_q   <= tmr_t'(eff.d_switch) - tmr_t'(1);
                        end else begin
                            state_q <= ST_SETUP;
                            cnt_q   <= tmr_t'(eff.d_setup);
                        end
                    end
                end
                ST_SWITCH: begin
                    if (cnt_done) begin
                        state_q <= ST_SETUP;
                        cnt_q   <= tmr_t'(eff.d_setup);
                    end else begin
                        cnt_q <= cnt_q - tmr_t'(1);
                    end
                end
                ST_SETUP: begin
                    if (cnt_done) begin
                        state_q <= ST_RUN;
                        cnt_q   <= half_len(eff.div) - tmr_t'(1);
                        edges_q <= edges_q - LAST_EDGE;
                    end else begin
                        cnt_q <= cnt_q - tmr_t'(1);
                    end
                end
                ST_RUN: begin
                    if (cnt_done) begin
                        if (edges_q == LAST_EDGE) begin
                            state_q <= ST_HOLD;
                            cnt_q   <= hold_len(eff) - tmr_t'(1);
                            edges_q <= '0;
                        end else begin
                            cnt_q   <= half_len(eff.div) - tmr_t'(1);
                            edges_q <= edges_q - LAST_EDGE;
                        end
                    end else begin
                        cnt_q <= cnt_q - tmr_t'(1);
                    end
                end
                ST_HOLD: begin
                    if (cnt_done) begin
                        state_q <= ST_GAP;
                        cnt_q   <= gap_len(eff) - tmr_t'(1);
                    end else begin
                        cnt_q <= cnt_q - tmr_t'(1);
                    end
                end
                ST_GAP: begin
                    if (cnt_done) begin
                        state_q <= ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q - tmr_t'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign state      = state_q;
    assign sclk       = sclk_q;
    assign sample_stb = samp_q;
    assign shift_stb  = shft_q;

endmodule

// File: rtl/spi_tgen_cs.sv
module spi_tgen_cs
    import spi_tgen_pkg::*;
(
    input  tgen_state_t     state,
    input  logic [CS_W-1:0] sel,
    output logic [CS_W-1:0] cs_n,
    output logic            busy,
    output logic            idle
);

    logic cs_on;

    always_comb begin
        cs_on = (state == ST_SETUP) || (state == ST_RUN) || (state == ST_HOLD);
        busy  = cs_on || (state == ST_SWITCH);
        idle  = (state == ST_IDLE);
    end

    for (genvar i = 0; i < CS_W; i++) begin : g_line
        assign cs_n[i] = ~cs_on | sel[i];
    end

endmodule

// File: rtl/spi_tgen.sv
module spi_tgen
    import spi_tgen_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             cpol,
    input  logic             cpha,
    input  logic [DIV_W-1:0] baud_div,
    input  logic [CS_W-1:0]  cs_sel,
    input  logic             cs_decode,
    input  logic [DLY_W-1:0] dly_setup,
    input  logic [DLY_W-1:0] dly_hold,
    input  logic [DLY_W-1:0] dly_switch,
    input  logic [DLY_W-1:0] dly_gap,
    input  logic             xfer_req,
    input  logic [LEN_W-1:0] xfer_len,
    output logic             sclk,
    output logic [CS_W-1:0]  cs_n,
    output logic             sample_stb,
    output logic             shift_stb,
    output logic             busy,
    output logic             idle
);

    tgen_cfg_t   cfg_in;
    tgen_cfg_t   eff;
    tgen_state_t state;
    logic        accept;
    logic        at_idle;

    always_comb begin
        cfg_in.cpol     = cpol;
        cfg_in.cpha     = cpha;
        cfg_in.div      = baud_div;
        cfg_in.cs_sel   = cs_sel;
        cfg_in.cs_dec   = cs_decode;
        cfg_in.d_setup  = dly_setup;
        cfg_in.d_hold   = dly_hold;
        cfg_in.d_switch = dly_switch;
        cfg_in.d_gap    = dly_gap;
        at_idle         = (state == ST_IDLE);
    end

    spi_tgen_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .enable  (enable),
        .accept  (accept),
        .at_idle (at_idle),
        .cfg_in  (cfg_in),
        .eff     (eff)
    );

    spi_tgen_seq #(.LEN_W(LEN_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .xfer_req   (xfer_req),
        .xfer_len   (xfer_len),
        .eff        (eff),
        .accept     (accept),
        .state      (state),
        .sclk       (sclk),
        .sample_stb (sample_stb),
        .shift_stb  (shift_stb)
    );

    spi_tgen_cs u_cs (
        .state (state),
        .sel   (eff.cs_sel),
        .cs_n  (cs_n),
        .busy  (busy),
        .idle  (idle)
    );

endmodule

// File: rtl/spi_tgen_chk.sv
module spi_tgen_chk #(
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             enable,
    input logic             xfer_req,
    input logic [LEN_W-1:0] xfer_len,
    input logic             sclk,
    input logic [3:0]       cs_n,
    input logic             sample_stb,
    input logic             shift_stb,
    input logic             busy,
    input logic             idle
);

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(sample_stb && shift_stb));

    // R3
    strobe_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (sample_stb || shift_stb) |-> (sclk != $past(sclk)));

    // R2
    release_level_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !idle) |-> $stable(sclk));

    // R2
    edge_scope_chk: assert property (@(posedge clk) disable iff (rst)
        (sclk != $past(sclk)) |-> (busy || idle));

    // R9
    cs_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (cs_n == 4'hF));

    // R9
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        idle |-> !busy);

    // R11
    hold_off_chk: assert property (@(posedge clk) disable iff (rst)
        (idle && !enable) |=> idle);

    // R11
    take_req_chk: assert property (@(posedge clk) disable iff (rst)
        (idle && enable && xfer_req && (xfer_len != '0)) |=> busy);

endmodule

bind spi_tgen spi_tgen_chk #(.LEN_W(LEN_W)) u_chk (.*);

// File: tb/spi_tgen_bench.sv
module spi_tgen_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic       cpol = 1'b0;
    logic       cpha = 1'b0;
    logic [3:0] baud_div = '0;
    logic [3:0] cs_sel = 4'hE;
    logic       cs_decode = 1'b0;
    logic [7:0] dly_setup = '0;
    logic [7:0] dly_hold = '0;
    logic [7:0] dly_switch = '0;
    logic [7:0] dly_gap = '0;
    logic       xfer_req = 1'b0;
    logic [7:0] xfer_len = '0;
    logic       sclk;
    logic [3:0] cs_n;
    logic       sample_stb;
    logic       shift_stb;
    logic       busy;
    logic       idle;

    spi_tgen u_spi_tgen (
        .clk(clk), .rst(rst), .enable(enable), .cpol(cpol), .cpha(cpha),
        .baud_div(baud_div), .cs_sel(cs_sel), .cs_decode(cs_decode),
        .dly_setup(dly_setup), .dly_hold(dly_hold), .dly_switch(dly_switch),
        .dly_gap(dly_gap), .xfer_req(xfer_req), .xfer_len(xfer_len),
        .sclk(sclk), .cs_n(cs_n), .sample_stb(sample_stb),
        .shift_stb(shift_stb), .busy(busy), .idle(idle)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // configuration the bench believes is captured
    bit       e_cpol, e_cpha, e_dec;
    int       e_div, e_setup, e_hold, e_sw, e_gap;
    bit [3:0] e_cs;
    bit       have_last = 1'b0;
    bit [4:0] last_key;

    // monitor state
    bit       mon_on = 1'b0;
    int       t_csa, t_csd, t_first, t_last, t_idle, gap_meas, n_csa;
    int       n_edges, n_samp, n_shift, spacing_err, strobe_err, cs_err, lvl_err;
    bit       busy_at_d, idle_at_d;
    logic     prev_sclk = 1'b0;
    logic [3:0] prev_cs = 4'hF;
    logic     prev_idle = 1'b1;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int period(input int d);
        return 2 * (d + 1);
    endfunction

    always @(posedge clk) begin
        #2;
        if (mon_on) begin
            if (prev_cs == 4'hF && cs_n != 4'hF) begin
                n_csa++;
                gap_meas = cyc - t_csd;
                t_csa = cyc;
            end
            if (prev_cs != 4'hF && cs_n == 4'hF) begin
                t_csd = cyc;
                busy_at_d = busy;
                idle_at_d = idle;
            end
            if (cs_n != 4'hF && cs_n != e_cs) cs_err++;
            if (sclk != prev_sclk) begin
                bit lead;
                bit exp_s;
                n_edges++;
                if (n_edges == 1) t_first = cyc;
                else if (cyc - t_last != e_div + 1) spacing_err++;
                t_last = cyc;
                lead = (sclk != e_cpol);
                exp_s = lead ^ e_cpha;
                if (sample_stb != exp_s || shift_stb != !exp_s) strobe_err++;
                n_samp += int'(sample_stb);
                n_shift += int'(shift_stb);
            end else if (sample_stb || shift_stb) begin
                strobe_err++;
            end
            if (cs_n == 4'hF && sclk != e_cpol) lvl_err++;
            if (idle && !prev_idle) t_idle = cyc;
        end
        prev_sclk = sclk;
        prev_cs = cs_n;
        prev_idle = idle;
    end

    task automatic clear_stats();
        t_csa = -1; t_csd = -1; t_first = -1; t_last = -1; t_idle = -1;
        gap_meas = -1; n_csa = 0; n_edges = 0; n_samp = 0; n_shift = 0;
        spacing_err = 0; strobe_err = 0; cs_err = 0; lvl_err = 0;
        busy_at_d = 1'b1; idle_at_d = 1'b1;
    endtask

    task automatic apply_cfg(input bit p, input bit h, input int d, input bit [3:0] cs,
                             input bit dec, input int su, input int ho,
                             input int sw, input int gp);
        @(negedge clk);
        enable = 1'b0;
        cpol = p; cpha = h; baud_div = 4'(d); cs_sel = cs; cs_decode = dec;
        dly_setup = 8'(su); dly_hold = 8'(ho); dly_switch = 8'(sw); dly_gap = 8'(gp);
        repeat (2) @(negedge clk);
        enable = 1'b1;
        e_cpol = p; e_cpha = h; e_div = d; e_cs = cs; e_dec = dec;
        e_setup = su; e_hold = ho; e_sw = sw; e_gap = gp;
        @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 6000 && t_idle < 0; k++) @(negedge clk);
    endtask

    task automatic do_xfer(input int n);
        int  e0;
        bit  sw_exp;
        bit [4:0] key;
        key = {e_dec, e_cs};
        sw_exp = have_last && (key != last_key) && (e_sw != 0);
        clear_stats();
        mon_on = 1'b1;
        @(negedge clk);
        xfer_req = 1'b1;
        xfer_len = 8'(n);
        e0 = cyc + 1;
        @(negedge clk);
        xfer_req = 1'b0;
        chk("R9 busy after accept", int'(busy), 1);
        chk("R9 idle after accept", int'(idle), 0);
        have_last = 1'b1;
        last_key = key;
        wait_idle();
        mon_on = 1'b0;
        chk("R9 transfer completes", int'(t_idle >= 0), 1);
        chk("R8 select assert cycle", t_csa - e0, sw_exp ? e_sw : 0);
        chk("R5 setup time", t_first - t_csa, e_setup + 1);
        chk("R1 edge count", n_edges, 2 * n);
        chk("R1 edge spacing errors", spacing_err, 0);
        chk("R3 strobe errors", strobe_err, 0);
        chk("R3 sample count", n_samp, n);
        chk("R3 shift count", n_shift, n);
        chk("R6 hold time", t_csd - t_last, e_hold + period(e_div) + 3);
        chk("R7 release to idle", t_idle - t_csd, e_gap + period(e_div));
        chk("R9 flags during release", int'(busy_at_d) + int'(idle_at_d), 0);
        chk("R4 select pattern errors", cs_err, 0);
        chk("R2 resting level errors", lvl_err, 0);
        chk("R2 final level", int'(sclk), int'(e_cpol));
    endtask

    task automatic b2b(input int n);
        clear_stats();
        mon_on = 1'b1;
        @(negedge clk);
        xfer_req = 1'b1;
        xfer_len = 8'(n);
        for (int k = 0; k < 6000 && n_csa < 2; k++) @(negedge clk);
        xfer_req = 1'b0;
        have_last = 1'b1;
        last_key = {e_dec, e_cs};
        t_idle = -1;
        wait_idle();
        mon_on = 1'b0;
        chk("R7 two assertions", n_csa, 2);
        chk("R7 back-to-back release", gap_meas, e_gap + period(e_div) + 1);
        chk("R7 release to idle", t_idle - t_csd, e_gap + period(e_div));
    endtask

    task automatic ignore_window(input string req);
        int bad;
        bad = 0;
        @(negedge clk);
        xfer_req = 1'b1;
        repeat (4) begin
            @(negedge clk);
            if (!idle || busy || cs_n != 4'hF) bad++;
        end
        xfer_req = 1'b0;
        chk(req, bad, 0);
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7771));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk("R12 sclk", int'(sclk), 0);
        chk("R12 cs_n", int'(cs_n), 15);
        chk("R12 idle", int'(idle), 1);
        chk("R12 busy", int'(busy), 0);
        chk("R12 strobes", int'(sample_stb) + int'(shift_stb), 0);

        // R11: requests ignored while enable is low
        ignore_window("R11 ignored while disabled");

        // fastest settings, first transfer never waits (R8)
        apply_cfg(0, 0, 0, 4'b1110, 0, 0, 0, 5, 0);
        do_xfer(1);
        // same device: no switch delay
        apply_cfg(1, 1, 3, 4'b1110, 0, 5, 4, 6, 7);
        do_xfer(3);
        // R8 one-hot device change
        apply_cfg(1, 0, 2, 4'b1101, 0, 2, 1, 6, 3);
        do_xfer(2);
        // R8 decoder mode, index 2 is another key
        apply_cfg(0, 1, 1, 4'd2, 1, 3, 2, 9, 4);
        do_xfer(2);
        // largest delays and divisor
        apply_cfg(0, 0, 15, 4'd2, 1, 255, 255, 255, 255);
        do_xfer(2);

        // R11: zero length ignored
        apply_cfg(0, 0, 1, 4'b1011, 0, 1, 1, 0, 3);
        xfer_len = 8'd0;
        ignore_window("R11 zero length ignored");

        // R7 request pending when the release time expires
        b2b(2);

        // R10 edits while enabled have no effect
        apply_cfg(0, 1, 2, 4'b0111, 0, 3, 2, 0, 2);
        @(negedge clk);
        baud_div = 4'd11; dly_setup = 8'd40; dly_hold = 8'd50;
        cpol = 1'b1; cs_sel = 4'b1110;
        repeat (3) @(negedge clk);
        chk("R10 resting level kept", int'(sclk), 0);
        do_xfer(2);

        // R10 edits during a transfer with enable dropped
        apply_cfg(1, 0, 3, 4'b0111, 0, 2, 3, 0, 2);
        fork
            do_xfer(4);
            begin
                repeat (8) @(negedge clk);
                enable = 1'b0;
                baud_div = 4'd12;
                dly_hold = 8'd99;
                dly_gap = 8'd77;
            end
        join

        // constrained random mix
        for (int it = 0; it < 24; it++) begin
            bit       dec;
            bit [3:0] cs;
            dec = 1'($urandom % 2);
            if (dec) cs = 4'($urandom % 15);
            else     cs = 4'hF & ~(4'b0001 << ($urandom % 4));
            apply_cfg(1'($urandom % 2), 1'($urandom % 2), int'($urandom % 16), cs, dec,
                      int'($urandom % 30), int'($urandom % 30),
                      int'($urandom % 12), int'($urandom % 30));
            do_xfer(1 + int'($urandom % 5));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule